// File: doc/BRIEF.md
# Boundary-Scan Self-Test Pattern Register

This block is the data register of a boundary-scan chain for a 20-bit two-way transceiver. It holds 40 cells: cells 0 to 19 sit on the A side and cells 20 to 39 on the B side. Each cell has a shift stage, clocked on the rising test-clock edge, and a shadow stage, clocked on the falling edge. The shadow stages drive either the device pins or the core-logic inputs, depending on which side is set up to drive.

A two-bit mode code chooses how the shift stages behave while the test access controller sits in run-test. In scan mode they behave as an ordinary capture/shift/update chain. In toggle mode the input-side cells sample their pins and the output-side cells invert themselves on every rising edge. In pattern mode the 40 shift stages step as a maximal-length linear-feedback shift register. In both self-test modes the shadows follow on every falling edge, so stimulus reaches the pins without any scan traffic. A non-zero seed has to be scanned in before pattern mode is started.

The controller, the instruction register and the pin drivers lie outside this block. All state qualifiers and data are plain level signals sampled on the test clock. There is no handshake and no back-pressure: each rising edge carries out exactly one action.

Top module: `bsr_selftest_reg`

## Requirements
- R1: While rst_n is low, all shift and shadow stages are cleared. This makes tdo and all four drive outputs zero.
- R2: With st_shift high and no higher-priority action, each rising edge moves cell i+1 into cell i and loads tdi into cell 39. tdo always shows cell 0.
- R3: With st_capture high and no self-test active, each rising edge loads cell i from its pin: a_pin_in[i] for i<20 and b_pin_in[i-20] otherwise. Capture wins over shift.
- R4: The shadow stages load from the shift stages on a falling edge when st_update is high. With no self-test active, they hold at all other times.
- R5: With b_is_out=1, the B shadows (cells 39:20) drive b_pin_drv and the A shadows drive a_core_drv, while a_pin_drv and b_core_drv are zero. With b_is_out=0 the roles are mirrored.
- R6: In toggle mode (mode=2'b01 with st_runtest high), each rising edge inverts every output-side shift stage and loads every input-side stage from its pin. Capture and shift are ignored.
- R7: In toggle mode the shadows load on every falling edge, so each output pin alternates in value on successive falling edges.
- R8: In pattern mode (mode=2'b10 with st_runtest high), each rising edge moves cell i-1 into cell i and loads cell 0 with the XOR of cells 39, 37, 20 and 18. This is the polynomial x^40+x^38+x^21+x^19+1.
- R9: In pattern mode the shadows load on every falling edge, so each new pattern reaches both pins and core inputs on the falling edge that follows it.
- R10: In pattern mode an all-zero register stays all-zero, and a non-zero register never becomes zero.
- R11: With st_runtest high and mode 2'b00 or 2'b11, and with capture and shift low, the shift stages and shadows hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; rising edge for shift stages, falling edge for shadows |
| rst_n | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial scan input into cell 39 |
| st_capture | input | 1 | Capture state qualifier |
| st_shift | input | 1 | Shift state qualifier |
| st_update | input | 1 | Update state qualifier |
| st_runtest | input | 1 | Run-test state qualifier |
| mode | input | 2 | 00 scan, 01 toggle, 10 pattern, 11 scan |
| b_is_out | input | 1 | 1: B side drives pins, A side feeds core; 0: mirrored |
| a_pin_in | input | 20 | A-side pin values |
| b_pin_in | input | 20 | B-side pin values |
| tdo | output | 1 | Serial scan output, cell 0 |
| a_pin_drv | output | 20 | A-side pin drive from shadows |
| b_pin_drv | output | 20 | B-side pin drive from shadows |
| a_core_drv | output | 20 | A-side shadows applied to core logic |
| b_core_drv | output | 20 | B-side shadows applied to core logic |

## Verification
On every rising edge, the assertions check the per-cycle relations of the shift stages: the one-place move in shift mode, the inversion of every output cell in toggle mode, the all-zero and non-zero invariants of the pattern generator, and the hold in the idle run-test codes. They also check that the side which is not driving puts out zeros. The exact feedback sequence over 100 steps, the priority of capture over shift, and the alternation of pin values on successive falling edges can only be shown by the bench. For both drive directions, the bench runs its own arithmetic model of the 40 cells and compares tdo and every drive output after each falling edge.

// File: rtl/bsr_pkg.sv
`timescale 1ns/1ps
package bsr_pkg;
  typedef enum logic [1:0] {
    BSR_SCAN   = 2'b00,
    BSR_TOGGLE = 2'b01,
    BSR_PRPG   = 2'b10,
    BSR_IDLE   = 2'b11
  } bsr_mode_e;
endpackage

// File: rtl/bsr_prpg_step.sv
`timescale 1ns/1ps
// One Fibonacci step: shift toward the top, feedback enters cell 0.
module bsr_prpg_step #(
  parameter int          N        = 40,
  parameter logic [N-1:0] TAP_MASK = '0
) (
  input  logic [N-1:0] cur,
  output logic [N-1:0] nxt
);
  logic fb;
  assign fb  = ^(cur & TAP_MASK);
  assign nxt = {cur[N-2:0], fb};
endmodule

// File: rtl/bsr_shift_chain.sv
`timescale 1ns/1ps
// Rising-edge shift stages with per-cell next-value selection.
module bsr_shift_chain #(
  parameter int SIDE_W = 20,
  localparam int N = 2 * SIDE_W
) (
  input  logic         tck,
  input  logic         rst_n,
  input  logic         sel_toggle,
  input  logic         sel_prpg,
  input  logic         capture,
  input  logic         shift,
  input  logic         tdi,
  input  logic         b_is_out,
  input  logic [N-1:0] pins,
  input  logic [N-1:0] prpg_nxt,
  output logic [N-1:0] sr_q
);
  logic [N-1:0] nxt;

  for (genvar i = 0; i < N; i++) begin : g_cell
    localparam bit ON_B = (i >= SIDE_W);
    logic is_out;
    logic shift_in;
    assign is_out = ON_B ? b_is_out : ~b_is_out;
    if (i == N - 1) begin : g_top
      assign shift_in = tdi;
    end else begin : g_mid
      assign shift_in = sr_q[i+1];
    end
    assign nxt[i] = sel_toggle ? (is_out ? ~sr_q[i] : pins[i]) :
                    sel_prpg   ? prpg_nxt[i] :
                    capture    ? pins[i] :
                    shift      ? shift_in :
                                 sr_q[i];
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= nxt;
  end
endmodule

// File: rtl/bsr_shadow_bank.sv
`timescale 1ns/1ps
// Falling-edge shadow stages.
module bsr_shadow_bank #(
  parameter int N = 40
) (
  input  logic         tck,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/bsr_selftest_reg.sv
`timescale 1ns/1ps
module bsr_selftest_reg #(
  parameter int SIDE_W = 20,
  parameter logic [2*SIDE_W-1:0] TAP_MASK =
    (40'(1) << 39) | (40'(1) << 37) | (40'(1) << 20) | (40'(1) << 18)
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              tdi,
  input  logic              st_capture,
  input  logic              st_shift,
  input  logic              st_update,
  input  logic              st_runtest,
  input  logic [1:0]        mode,
  input  logic              b_is_out,
  input  logic [SIDE_W-1:0] a_pin_in,
  input  logic [SIDE_W-1:0] b_pin_in,
  output logic              tdo,
  output logic [SIDE_W-1:0] a_pin_drv,
  output logic [SIDE_W-1:0] b_pin_drv,
  output logic [SIDE_W-1:0] a_core_drv,
  output logic [SIDE_W-1:0] b_core_drv
);
  import bsr_pkg::*;
  localparam int N = 2 * SIDE_W;

  bsr_mode_e    mode_e;
  logic         sel_toggle;
  logic         sel_prpg;
  logic [N-1:0] sr_q;
  logic [N-1:0] sh_q;
  logic [N-1:0] prpg_nxt;

  assign mode_e     = bsr_mode_e'(mode);
  assign sel_toggle = st_runtest && (mode_e == BSR_TOGGLE);
  assign sel_prpg   = st_runtest && (mode_e == BSR_PRPG);

  bsr_prpg_step #(.N(N), .TAP_MASK(TAP_MASK)) u_step (
    .cur (sr_q),
    .nxt (prpg_nxt)
  );

  bsr_shift_chain #(.SIDE_W(SIDE_W)) u_chain (
    .tck        (tck),
    .rst_n      (rst_n),
    .sel_toggle (sel_toggle),
    .sel_prpg   (sel_prpg),
    .capture    (st_capture),
    .shift      (st_shift),
    .tdi        (tdi),
    .b_is_out   (b_is_out),
    .pins       ({b_pin_in, a_pin_in}),
    .prpg_nxt   (prpg_nxt),
    .sr_q       (sr_q)
  );

  bsr_shadow_bank #(.N(N)) u_shadow (
    .tck   (tck),
    .rst_n (rst_n),
    .load  (st_update || sel_toggle || sel_prpg),
    .d     (sr_q),
    .q     (sh_q)
  );

  assign tdo        = sr_q[0];
  assign a_pin_drv  = b_is_out ? '0 : sh_q[SIDE_W-1:0];
  assign a_core_drv = b_is_out ? sh_q[SIDE_W-1:0] : '0;
  assign b_pin_drv  = b_is_out ? sh_q[N-1:SIDE_W] : '0;
  assign b_core_drv = b_is_out ? '0 : sh_q[N-1:SIDE_W];
endmodule

// File: rtl/bsr_selftest_reg_chk.sv
`timescale 1ns/1ps
module bsr_selftest_reg_chk #(
  parameter int SIDE_W = 20,
  localparam int N = 2 * SIDE_W
) (
  input logic              tck,
  input logic              rst_n,
  input logic              tdi,
  input logic              st_capture,
  input logic              st_shift,
  input logic              st_runtest,
  input logic [1:0]        mode,
  input logic              b_is_out,
  input logic [N-1:0]      sr_q,
  input logic [SIDE_W-1:0] a_pin_drv,
  input logic [SIDE_W-1:0] b_core_drv,
  input logic [SIDE_W-1:0] b_pin_drv,
  input logic [SIDE_W-1:0] a_core_drv
);
  localparam logic [N-1:0] B_HALF = {{SIDE_W{1'b1}}, {SIDE_W{1'b0}}};
  logic [N-1:0] out_mask;
  logic         t_on, p_on, self_on;
  assign out_mask = b_is_out ? B_HALF : ~B_HALF;
  assign t_on     = st_runtest && (mode == 2'b01);
  assign p_on     = st_runtest && (mode == 2'b10);
  assign self_on  = t_on || p_on;

  // R6
  toggle_invert_chk: assert property (@(posedge tck) disable iff (!rst_n)
    t_on |=> (((sr_q ^ $past(sr_q)) & $past(out_mask)) == $past(out_mask)));

  // R10
  prpg_zero_stuck_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (p_on && sr_q == '0) |=> (sr_q == '0));

  // R10
  prpg_nonzero_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (p_on && sr_q != '0) |=> (sr_q != '0));

  // R2
  shift_move_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (st_shift && !st_capture && !self_on) |=>
      (sr_q[N-2:0] == $past(sr_q[N-1:1]) && sr_q[N-1] == $past(tdi)));

  // R11
  idle_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (st_runtest && !self_on && !st_capture && !st_shift) |=> $stable(sr_q));

  // R5
  side_quiet_chk: assert property (@(posedge tck) disable iff (!rst_n)
    b_is_out ? (a_pin_drv == '0 && b_core_drv == '0)
             : (b_pin_drv == '0 && a_core_drv == '0));
endmodule

bind bsr_selftest_reg bsr_selftest_reg_chk #(.SIDE_W(SIDE_W)) u_chk (
  .tck        (tck),
  .rst_n      (rst_n),
  .tdi        (tdi),
  .st_capture (st_capture),
  .st_shift   (st_shift),
  .st_runtest (st_runtest),
  .mode       (mode),
  .b_is_out   (b_is_out),
  .sr_q       (sr_q),
  .a_pin_drv  (a_pin_drv),
  .b_core_drv (b_core_drv),
  .b_pin_drv  (b_pin_drv),
  .a_core_drv (a_core_drv)
);

// File: tb/bsr_selftest_reg_tb.sv
`timescale 1ns/1ps
module bsr_selftest_reg_tb;
  logic        tck = 1'b0;
  logic        rst_n = 1'b0;
  logic        tdi = 1'b0;
  logic        st_capture = 1'b0, st_shift = 1'b0, st_update = 1'b0, st_runtest = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        b_is_out = 1'b1;
  logic [19:0] a_pin_in = '0, b_pin_in = '0;
  logic        tdo;
  logic [19:0] a_pin_drv, b_pin_drv, a_core_drv, b_core_drv;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [39:0] m_sr = '0;
  logic [39:0] m_sh = '0;

  bsr_selftest_reg u_dut (
    .tck(tck), .rst_n(rst_n), .tdi(tdi), .st_capture(st_capture),
    .st_shift(st_shift), .st_update(st_update), .st_runtest(st_runtest),
    .mode(mode), .b_is_out(b_is_out), .a_pin_in(a_pin_in), .b_pin_in(b_pin_in),
    .tdo(tdo), .a_pin_drv(a_pin_drv), .b_pin_drv(b_pin_drv),
    .a_core_drv(a_core_drv), .b_core_drv(b_core_drv)
  );

  initial forever #2.5 tck = ~tck;

  function automatic logic [39:0] omask();
    return b_is_out ? {20'hFFFFF, 20'h0} : {20'h0, 20'hFFFFF};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One test-clock period; inputs are set after a falling edge, checked after the next.
  task automatic tick(input string tag);
    logic [39:0] pins;
    logic [39:0] om;
    logic sel_t, sel_p;
    pins  = {b_pin_in, a_pin_in};
    om    = omask();
    sel_t = st_runtest && mode == 2'b01;
    sel_p = st_runtest && mode == 2'b10;
    @(posedge tck);
    if (sel_t)           m_sr = (~m_sr & om) | (pins & ~om);
    else if (sel_p)      m_sr = {m_sr[38:0], m_sr[39] ^ m_sr[37] ^ m_sr[20] ^ m_sr[18]};
    else if (st_capture) m_sr = pins;
    else if (st_shift)   m_sr = {tdi, m_sr[39:1]};
    @(negedge tck);
    if (st_update || sel_t || sel_p) m_sh = m_sr;
    #1;
    chk(tdo == m_sr[0], {tag, " tdo"}, 64'(tdo), 64'(m_sr[0]));
    chk({b_pin_drv, a_pin_drv} == (m_sh & om), {tag, " pin drive"},
        64'({b_pin_drv, a_pin_drv}), 64'(m_sh & om));
    chk({b_core_drv, a_core_drv} == (m_sh & ~om), {tag, " core drive R5"},
        64'({b_core_drv, a_core_drv}), 64'(m_sh & ~om));
  endtask

  task automatic scan_in(input logic [39:0] v, input string tag);
    st_shift = 1'b1;
    for (int i = 0; i < 40; i++) begin
      tdi = v[i];
      tick(tag);
    end
    st_shift = 1'b0;
    tdi = 1'b0;
  endtask

  task automatic do_update();
    st_update = 1'b1;
    tick("R4 update");
    st_update = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [39:0] prev;
    logic [39:0] seed;
    repeat (3) @(negedge tck);
    #1;
    // R1: reset state
    chk(tdo == 1'b0 && {a_pin_drv, b_pin_drv, a_core_drv, b_core_drv} == '0,
        "R1 reset outputs", 64'({a_pin_drv, b_pin_drv}), 64'h0);
    rst_n = 1'b1;
    tick("R1 after reset");

    for (int side = 0; side < 2; side++) begin
      b_is_out = side[0];
      seed = 40'hC3_5A96_0F1E ^ (40'(side) * 40'h11_2233_4455);
      // R2: serial load, tdo checked on every cycle
      scan_in(seed, "R2 shift");
      chk(m_sr == seed, "R2 model seed", 64'(m_sr), 64'(seed));
      // R4 and R5: update then hold
      do_update();
      for (int k = 0; k < 3; k++) tick("R4 hold");
      // R3: capture, then capture together with shift
      a_pin_in = 20'hA5F0C ^ 20'(side * 7);
      b_pin_in = 20'h3C96E;
      st_capture = 1'b1;
      tick("R3 capture");
      a_pin_in = 20'h0F0F1;
      st_shift = 1'b1;
      tdi = 1'b1;
      tick("R3 capture over shift");
      st_capture = 1'b0;
      st_shift = 1'b0;
      do_update();

      // R6 and R7: toggle mode with changing pins
      scan_in(seed, "R2 reseed");
      st_runtest = 1'b1;
      mode = 2'b01;
      prev = {b_pin_drv, a_pin_drv};
      for (int k = 0; k < 10; k++) begin
        a_pin_in = 20'(k * 40503 + 11);
        b_pin_in = 20'(k * 92821 + 5);
        tick("R6 toggle");
        if (k > 0)
          chk((({b_pin_drv, a_pin_drv}) ^ prev) == omask(), "R7 alternation",
              64'({b_pin_drv, a_pin_drv} ^ prev), 64'(omask()));
        prev = {b_pin_drv, a_pin_drv};
      end
      // R11: idle run-test codes hold everything
      mode = 2'b00;
      for (int k = 0; k < 3; k++) tick("R11 mode 00 hold");
      mode = 2'b11;
      for (int k = 0; k < 3; k++) tick("R11 mode 11 hold");
      st_runtest = 1'b0;
      mode = 2'b00;

      // R8 and R9: 100 pattern steps from a non-zero seed
      scan_in(seed ^ 40'h80_0000_0001, "R2 prpg seed");
      st_runtest = 1'b1;
      mode = 2'b10;
      for (int k = 0; k < 100; k++) tick("R8 R9 prpg step");
      chk(m_sr != '0, "R10 non-zero stays", 64'(m_sr), 64'h1);
      st_runtest = 1'b0;
      mode = 2'b00;

      // R10: zero seed stays zero
      scan_in('0, "R2 zero seed");
      st_runtest = 1'b1;
      mode = 2'b10;
      for (int k = 0; k < 8; k++) begin
        tick("R10 zero stuck");
        chk({b_pin_drv, a_pin_drv, b_core_drv, a_core_drv} == '0, "R10 zero drives",
            64'({b_pin_drv, a_pin_drv}), 64'h0);
      end
      st_runtest = 1'b0;
      mode = 2'b00;
    end
    finish_run();
  end
endmodule